// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Clear Unit

This block gathers the per-channel completion and fault events of a multi-channel DMA engine into a small set of software-readable status words. It also raises one interrupt line toward the system interrupt controller. Each channel has two event types:

- A transfer-done event. A channel posts it only once every datum of its current descriptor has reached the destination.
- A bus-fault event.

Each event type sets its own sticky latch. The latches are seen through three layers of status words:

- Raw views show the latches as they are.
- Masked views show the latches gated by per-channel enables. The done-event enable comes from the channel's control word and the fault enable from the channel's configuration word, so the two enables are separate inputs.
- A summary view ORs, for each channel, its masked done bit with its masked fault bit.

Software acknowledges events selectively. It writes ones to a done-clear word or a fault-clear word, and each one bit clears that channel's latch of that type only. The interrupt output is high whenever any bit of the summary view is set.

Top module: `dma_irq_status`

## Requirements
- R1: After reset, all done and fault latches are 0. Every status word reads 0 and `irq` is 0.
- R2: A 1 on `done_evt[i]` at a rising clock edge sets done latch i. The latch stays set after the event input falls, until it is cleared. No latch sets without an event.
- R3: A 1 on `fault_evt[i]` at a rising clock edge sets fault latch i. The latch stays set until it is cleared.
- R4: The raw done word (address 1) and the raw fault word (address 2) show every channel's latch in bit i for channel i. The enables have no effect on these words.
- R5: The masked done word (address 3) reads raw done AND `done_en`.
- R6: The masked fault word (address 4) reads raw fault AND `fault_en`.
- R7: The summary word (address 0) reads, per channel, masked done OR masked fault.
- R8: A write to address 5 clears done latch i for every data bit i that is 1. Zero bits have no effect, and the fault latches are untouched. A write to any of the read-only addresses 0 to 4 changes nothing.
- R9: A write to address 6 clears fault latch i for every data bit i that is 1. Zero bits and the done latches are unaffected.
- R10: When an event and a clear of the same latch fall on the same edge, the event wins and the latch stays set.
- R11: `irq` is the OR of all summary bits and follows the latches and enables without delay (default `IRQ_REG`=0).
- R12: Reads have no side effects. `rd_data` is combinational from `rd_addr`, and bits above the channel count read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_evt | input | NCH | Per-channel transfer-done event pulses |
| fault_evt | input | NCH | Per-channel bus-fault event pulses |
| done_en | input | NCH | Per-channel enable for done status |
| fault_en | input | NCH | Per-channel enable for fault status |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | AW | Register read address |
| rd_data | output | DW | Register read data |
| irq | output | 1 | Combined interrupt request |

## Verification
The latches are loaded with distinct, overlapping channel patterns for done and fault events. The patterns are chosen so that the raw, masked and summary words all differ, which separates a masking error from a combining error. Enables that cover only part of the pending bits show whether `irq` tracks the masked summary rather than the raw latches. Clears are exercised with partial one patterns, zero patterns and writes to read-only addresses. A same-edge event/clear collision confirms the priority of the event.

// File: rtl/dic_pkg.sv
package dic_pkg;
   typedef enum logic [2:0] {
      RG_SUMMARY  = 3'd0,
      RG_RAW_DONE = 3'd1,
      RG_RAW_FLT  = 3'd2,
      RG_MSK_DONE = 3'd3,
      RG_MSK_FLT  = 3'd4,
      RG_CLR_DONE = 3'd5,
      RG_CLR_FLT  = 3'd6
   } dic_reg_e;
   localparam int unsigned DIC_MIN_AW = 3;
endpackage

// File: rtl/dic_evt_bank.sv
module dic_evt_bank #(
   parameter int unsigned NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] set_i,
   input  logic [NCH-1:0] clr_i,
   output logic [NCH-1:0] lat_o
);
   for (genvar g = 0; g < NCH; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           lat_o[g] <= 1'b0;
         else if (set_i[g])    lat_o[g] <= 1'b1;   // event has priority over clear
         else if (clr_i[g])    lat_o[g] <= 1'b0;
      end
   end
endmodule

// File: rtl/dic_view.sv
module dic_view #(
   parameter int unsigned NCH = 8
) (
   input  logic [NCH-1:0] raw_done_i,
   input  logic [NCH-1:0] raw_flt_i,
   input  logic [NCH-1:0] en_done_i,
   input  logic [NCH-1:0] en_flt_i,
   output logic [NCH-1:0] msk_done_o,
   output logic [NCH-1:0] msk_flt_o,
   output logic [NCH-1:0] summary_o
);
   always_comb begin
      msk_done_o = raw_done_i & en_done_i;
      msk_flt_o  = raw_flt_i  & en_flt_i;
      summary_o  = msk_done_o | msk_flt_o;
   end
endmodule

// File: rtl/dic_regif.sv
module dic_regif
   import dic_pkg::*;
#(
   parameter int unsigned NCH = 8,
   parameter int unsigned DW  = 32,
   parameter int unsigned AW  = 3
) (
   input  logic           wr_en_i,
   input  logic [AW-1:0]  wr_addr_i,
   input  logic [NCH-1:0] wr_bits_i,
   input  logic [AW-1:0]  rd_addr_i,
   input  logic [NCH-1:0] summary_i,
   input  logic [NCH-1:0] raw_done_i,
   input  logic [NCH-1:0] raw_flt_i,
   input  logic [NCH-1:0] msk_done_i,
   input  logic [NCH-1:0] msk_flt_i,
   output logic [NCH-1:0] clr_done_o,
   output logic [NCH-1:0] clr_flt_o,
   output logic [DW-1:0]  rd_data_o
);
   localparam logic [AW-1:0] A_SUM  = AW'(RG_SUMMARY);
   localparam logic [AW-1:0] A_RDN  = AW'(RG_RAW_DONE);
   localparam logic [AW-1:0] A_RFL  = AW'(RG_RAW_FLT);
   localparam logic [AW-1:0] A_MDN  = AW'(RG_MSK_DONE);
   localparam logic [AW-1:0] A_MFL  = AW'(RG_MSK_FLT);
   localparam logic [AW-1:0] A_CDN  = AW'(RG_CLR_DONE);
   localparam logic [AW-1:0] A_CFL  = AW'(RG_CLR_FLT);

   function automatic logic [DW-1:0] widen(input logic [NCH-1:0] v);
      logic [DW-1:0] r;
      r = '0;
      r[NCH-1:0] = v;
      return r;
   endfunction

   always_comb begin
      clr_done_o = (wr_en_i && wr_addr_i == A_CDN) ? wr_bits_i : '0;
      clr_flt_o  = (wr_en_i && wr_addr_i == A_CFL) ? wr_bits_i : '0;
   end

   always_comb begin
      unique case (rd_addr_i)
         A_SUM:   rd_data_o = widen(summary_i);
         A_RDN:   rd_data_o = widen(raw_done_i);
         A_RFL:   rd_data_o = widen(raw_flt_i);
         A_MDN:   rd_data_o = widen(msk_done_i);
         A_MFL:   rd_data_o = widen(msk_flt_i);
         default: rd_data_o = '0;
      endcase
   end
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
   import dic_pkg::*;
#(
   parameter int unsigned NCH     = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned AW      = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] done_evt,
   input  logic [NCH-1:0] fault_evt,
   input  logic [NCH-1:0] done_en,
   input  logic [NCH-1:0] fault_en,
   input  logic           wr_en,
   input  logic [AW-1:0]  wr_addr,
   input  logic [DW-1:0]  wr_data,
   input  logic [AW-1:0]  rd_addr,
   output logic [DW-1:0]  rd_data,
   output logic           irq
);
   initial begin
      if (NCH < 1 || NCH > DW) $error("dma_irq_status: NCH must be 1..DW");
      if (AW < DIC_MIN_AW)     $error("dma_irq_status: AW too small for register map");
   end

   logic [NCH-1:0] raw_done, raw_flt, msk_done, msk_flt, summary;
   logic [NCH-1:0] clr_done, clr_flt;

   if (DW > NCH) begin : g_hi
      logic wr_hi_unused;
      assign wr_hi_unused = ^wr_data[DW-1:NCH];
   end

   dic_evt_bank #(.NCH(NCH)) u_done_bank (
      .clk(clk), .rst_n(rst_n), .set_i(done_evt), .clr_i(clr_done), .lat_o(raw_done));

   dic_evt_bank #(.NCH(NCH)) u_flt_bank (
      .clk(clk), .rst_n(rst_n), .set_i(fault_evt), .clr_i(clr_flt), .lat_o(raw_flt));

   dic_view #(.NCH(NCH)) u_view (
      .raw_done_i(raw_done), .raw_flt_i(raw_flt),
      .en_done_i(done_en),   .en_flt_i(fault_en),
      .msk_done_o(msk_done), .msk_flt_o(msk_flt), .summary_o(summary));

   dic_regif #(.NCH(NCH), .DW(DW), .AW(AW)) u_regif (
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_bits_i(wr_data[NCH-1:0]),
      .rd_addr_i(rd_addr),
      .summary_i(summary), .raw_done_i(raw_done), .raw_flt_i(raw_flt),
      .msk_done_i(msk_done), .msk_flt_i(msk_flt),
      .clr_done_o(clr_done), .clr_flt_o(clr_flt), .rd_data_o(rd_data));

   if (IRQ_REG) begin : g_irq_ff
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |summary;
      end
   end else begin : g_irq_comb
      assign irq = |summary;
   end
endmodule

// File: rtl/dma_irq_status_chk.sv
module dma_irq_status_chk #(
   parameter int unsigned NCH     = 8,
   parameter int unsigned DW      = 32,
   parameter int unsigned AW      = 3,
   parameter bit          IRQ_REG = 1'b0
) (
   input logic           clk,
   input logic           rst_n,
   input logic [NCH-1:0] done_evt,
   input logic [NCH-1:0] fault_evt,
   input logic [NCH-1:0] done_en,
   input logic [NCH-1:0] fault_en,
   input logic           wr_en,
   input logic [AW-1:0]  wr_addr,
   input logic [DW-1:0]  wr_data,
   input logic [AW-1:0]  rd_addr,
   input logic [DW-1:0]  rd_data,
   input logic           irq,
   input logic [NCH-1:0] raw_done,
   input logic [NCH-1:0] raw_flt
);
   logic [NCH-1:0] wclr_done, wclr_flt;
   assign wclr_done = (wr_en && wr_addr == AW'(5)) ? wr_data[NCH-1:0] : '0;
   assign wclr_flt  = (wr_en && wr_addr == AW'(6)) ? wr_data[NCH-1:0] : '0;

   AST_DONE_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_done & $past(done_evt)) == $past(done_evt)));          // R2
   AST_FLT_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_flt & $past(fault_evt)) == $past(fault_evt)));         // R3
   AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((raw_done & ~$past(raw_done) & ~$past(done_evt)) == '0));    // R2
   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(raw_done) & ~$past(wclr_done)) & ~raw_done)) == '0)); // R8
   AST_FLT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((($past(raw_flt) & ~$past(wclr_flt)) & ~raw_flt)) == '0));    // R9
   AST_MASKED_DONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_addr == AW'(3)) |-> (rd_data[NCH-1:0] == (raw_done & done_en)));  // R5

   if (!IRQ_REG) begin : g_irq_chk
      AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
         irq == |((raw_done & done_en) | (raw_flt & fault_en)));             // R11
   end
endmodule

bind dma_irq_status dma_irq_status_chk #(
   .NCH(NCH), .DW(DW), .AW(AW), .IRQ_REG(IRQ_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .fault_evt(fault_evt),
   .done_en(done_en), .fault_en(fault_en), .wr_en(wr_en), .wr_addr(wr_addr),
   .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
   .raw_done(raw_done), .raw_flt(raw_flt)
);

// File: tb/sim_dma_irq_status.sv
module sim_dma_irq_status;
   localparam int NCH = 8;
   localparam int DW  = 32;
   localparam int AW  = 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [NCH-1:0] done_evt = '0, fault_evt = '0, done_en = '0, fault_en = '0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  wr_addr = '0, rd_addr = '0;
   logic [DW-1:0]  wr_data = '0;
   logic [DW-1:0]  rd_data;
   logic           irq;

   int total = 0, bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;   // 250 MHz

   dma_irq_status #(.NCH(NCH), .DW(DW), .AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .fault_evt(fault_evt),
      .done_en(done_en), .fault_en(fault_en), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic rd(input int a, output logic [DW-1:0] d);
      @(negedge clk);
      rd_addr = AW'(a);
      #1 d = rd_data;
   endtask

   task automatic expect_reg(input string req, input int a, input logic [DW-1:0] exp);
      logic [DW-1:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse(input logic [NCH-1:0] dn, input logic [NCH-1:0] fl);
      @(negedge clk);
      done_evt = dn; fault_evt = fl;
      @(negedge clk);
      done_evt = '0; fault_evt = '0;
   endtask

   task automatic t_reset;
      for (int a = 0; a < 7; a++) expect_reg("R1 reset view", a, '0);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_done_set;
      done_en = 8'h0F;
      pulse(8'h81, 8'h00);
      repeat (3) @(negedge clk);
      expect_reg("R2 R4 raw done held", 1, 32'h81);
      expect_reg("R5 masked done", 3, 32'h01);
      expect_reg("R7 summary done only", 0, 32'h01);
      check("R11 irq high", {31'b0, irq}, 32'h1);
   endtask

   task automatic t_fault_set;
      fault_en = 8'hF0;
      pulse(8'h00, 8'h30);
      expect_reg("R3 raw fault", 2, 32'h30);
      expect_reg("R6 masked fault", 4, 32'h30);
      expect_reg("R7 summary or", 0, 32'h31);
   endtask

   task automatic t_read_clean;
      expect_reg("R12 first read", 1, 32'h81);
      expect_reg("R12 second read", 1, 32'h81);
      expect_reg("R12 clear addr reads zero", 5, 32'h0);
   endtask

   task automatic t_clear_done;
      wr(5, 32'h01);
      expect_reg("R8 done cleared selectively", 1, 32'h80);
      expect_reg("R8 fault untouched", 2, 32'h30);
      wr(5, 32'h00);
      expect_reg("R8 zero write no effect", 1, 32'h80);
      wr(1, 32'hFF);
      expect_reg("R8 read-only write ignored", 1, 32'h80);
   endtask

   task automatic t_clear_fault;
      wr(6, 32'h10);
      expect_reg("R9 fault cleared selectively", 2, 32'h20);
      expect_reg("R9 done untouched", 1, 32'h80);
   endtask

   task automatic t_race;
      @(negedge clk);
      done_evt = 8'h02; wr_en = 1'b1; wr_addr = AW'(5); wr_data = 32'h02;
      @(negedge clk);
      done_evt = '0; wr_en = 1'b0; wr_data = '0;
      expect_reg("R10 event beats clear", 1, 32'h82);
   endtask

   task automatic t_irq_mask;
      wr(5, 32'hFF);
      wr(6, 32'hFF);
      expect_reg("R8 R9 all cleared summary", 0, 32'h0);
      check("R11 irq low after clear", {31'b0, irq}, 32'h0);
      done_en = '0; fault_en = '0;
      pulse(8'h04, 8'h00);
      expect_reg("R4 raw set while disabled", 1, 32'h04);
      check("R11 irq low while masked", {31'b0, irq}, 32'h0);
      @(negedge clk);
      done_en = 8'h04;
      #1 check("R11 irq follows enable", {31'b0, irq}, 32'h1);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_done_set();
      t_fault_set();
      t_read_clean();
      t_clear_done();
      t_clear_fault();
      t_race();
      t_irq_mask();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule